// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block decides how a 32-bit core enters a handler. The core presents a pending exception (valid plus 12-bit event code), a pending interrupt (valid, 4-bit level and 12-bit event code), and its current status word, program counter, stack register (R15), vector base and delay-slot flag, together with its sleep state. The core pulses `take_event` for one cycle when it can switch flow. On that clock edge the block classifies the request and does one of four things. It enters an exception handler. It enters an interrupt handler. It raises a reset request. Or it does nothing because the interrupt is masked.

On an entry, the block latches the following in the same edge: the saved status, the saved PC and the saved stack pointer, the new status word, the handler address, and the matching event-code register. It also pulses `entered` for one cycle. `slot_clear` and `wake` tell the core to drop its delay-slot flag and leave sleep. The handler address depends on the event class: a fixed reset address, or the vector base plus one of three offsets.

Top module: `evt_entry_seq`

## Requirements
- R1: When an exception and an interrupt are both pending at a `take_event` edge, the exception is taken. `entry_exc` is 1 and `intevt` keeps its value.
- R2: If status bit 28 (block) is set and the exception code is not 0x1E0, the edge produces a one-cycle `reset_req` and no entry. `entered` stays 0 and all saved registers keep their values. Code 0x1E0 with block set enters normally.
- R3: With status bit 28 set, an interrupt is ignored unless `sleep_in` is 1. Any accepted event pulses `wake` when `sleep_in` was 1.
- R4: An interrupt is accepted only when `irq_level` is strictly greater than status bits [7:4]. Otherwise it is ignored.
- R5: On entry, `ssr` takes the status word, `sgr` takes R15, and `sr_new` is the status word with bits 30, 29 and 28 set.
- R6: If the delay-slot flag is set, the saved PC is the PC minus 2 and `slot_clear` pulses. An interrupt is never accepted while the delay-slot flag is set.
- R7: Exception codes 0x000, 0x020 and 0x140 go to address 0xA0000000. They clear status bit 15 and set status bits [7:4] to 0xF.
- R8: Exception codes 0x040 and 0x060 go to base+0x400, and every other exception goes to base+0x100. Every taken exception writes its code to `expevt`.
- R9: Exception code 0x160 saves the PC plus 2, after any delay-slot correction.
- R10: An accepted interrupt writes its code to `intevt`, goes to base+0x600, and leaves `expevt` unchanged.
- R11: After reset all outputs are 0. Outputs change only on an edge where `take_event` is 1. `entered` and `reset_req` last one cycle, and an ignored event changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| take_event | input | 1 | One-cycle strobe: evaluate pending events on this edge |
| exc_valid | input | 1 | An exception is pending |
| exc_code | input | 12 | Exception event code |
| irq_valid | input | 1 | An interrupt is pending |
| irq_level | input | 4 | Interrupt priority level |
| irq_code | input | 12 | Interrupt event code |
| sr_in | input | 32 | Current status word |
| pc_in | input | 32 | Current program counter |
| r15_in | input | 32 | Current stack register |
| vbr_in | input | 32 | Vector base |
| dslot_in | input | 1 | A delay-slot instruction is executing |
| sleep_in | input | 1 | Core is in sleep state |
| entered | output | 1 | Handler entry happened on the last edge |
| entry_exc | output | 1 | Last entry was an exception (0: interrupt) |
| reset_req | output | 1 | Masked exception escalated to a reset request |
| slot_clear | output | 1 | Core must clear its delay-slot flag |
| wake | output | 1 | Core must leave sleep state |
| ssr | output | 32 | Saved status word |
| spc | output | 32 | Saved program counter |
| sgr | output | 32 | Saved stack register |
| sr_new | output | 32 | Status word for the handler |
| pc_new | output | 32 | Handler address |
| expevt | output | 12 | Exception event register |
| intevt | output | 12 | Interrupt event register |

## Verification
The bound checker checks several rules on every cycle. Entries and reset requests appear only after a strobe. An entry always sets the three mode bits and saves the previous status. A reset request never comes with an entry. An interrupt entry always goes to base+0x600 above the mask level, and an exception that was pending always wins. Only the bench sweeps show the remaining behaviour: the full class-to-vector map, the trap and delay-slot corrections to the saved PC, the exact handling of code 0x1E0 under block, and the fact that ignored events leave every register intact. The sweeps cover every level against every mask with block, sleep and delay-slot in all combinations, and every exception code in the range.

// File: rtl/evt_pkg.sv
package evt_pkg;

  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_EXC  = 2'd1,
    EV_IRQ  = 2'd2,
    EV_RST  = 2'd3
  } ev_kind_e;

  localparam int CODE_W   = 12;
  localparam int BIT_BL   = 28;
  localparam int BIT_RB   = 29;
  localparam int BIT_MD   = 30;
  localparam int BIT_FD   = 15;
  localparam int IMASK_LO = 4;

  localparam logic [CODE_W-1:0] CODE_UNBLOCKED = 12'h1E0;
  localparam logic [CODE_W-1:0] CODE_TRAP      = 12'h160;
  localparam logic [CODE_W-1:0] CODE_TLB_RD    = 12'h040;
  localparam logic [CODE_W-1:0] CODE_TLB_WR    = 12'h060;

  localparam int N_HARD = 3;
  localparam logic [CODE_W-1:0] HARD_CODES [N_HARD] = '{12'h000, 12'h020, 12'h140};

endpackage

// File: rtl/evt_arbiter.sv
module evt_arbiter
  import evt_pkg::*;
#(
  parameter int LVL_W = 4
) (
  input  logic              exc_valid,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              irq_valid,
  input  logic [LVL_W-1:0]  irq_level,
  input  logic [LVL_W-1:0]  imask,
  input  logic              blocked,
  input  logic              sleeping,
  input  logic              in_slot,
  output ev_kind_e          kind
);

  logic irq_ok;

  always_comb begin
    irq_ok = irq_valid && !in_slot && (!blocked || sleeping) && (irq_level > imask);
    kind   = EV_NONE;
    if (exc_valid) begin
      if (blocked && (exc_code != CODE_UNBLOCKED)) kind = EV_RST;
      else                                         kind = EV_EXC;
    end else if (irq_ok) begin
      kind = EV_IRQ;
    end
  end

endmodule

// File: rtl/evt_target.sv
module evt_target
  import evt_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          LVL_W    = 4,
  parameter logic [31:0] FIXED_PC = 32'hA000_0000,
  parameter logic [31:0] OFS_GEN  = 32'h0000_0100,
  parameter logic [31:0] OFS_TLB  = 32'h0000_0400,
  parameter logic [31:0] OFS_IRQ  = 32'h0000_0600
) (
  input  ev_kind_e          kind,
  input  logic [CODE_W-1:0] exc_code,
  input  logic [XLEN-1:0]   sr,
  input  logic [XLEN-1:0]   pc,
  input  logic [XLEN-1:0]   vbr,
  input  logic              in_slot,
  output logic [XLEN-1:0]   tgt_pc,
  output logic [XLEN-1:0]   tgt_sr,
  output logic [XLEN-1:0]   save_pc
);

  localparam logic [XLEN-1:0] STEP = XLEN'(2);

  logic [N_HARD-1:0] hard_hit;
  logic              is_hard;
  logic              is_tlb;
  logic              is_trap;

  for (genvar g = 0; g < N_HARD; g++) begin : g_hard
    assign hard_hit[g] = (exc_code == HARD_CODES[g]);
  end

  assign is_hard = |hard_hit;
  assign is_tlb  = (exc_code == CODE_TLB_RD) || (exc_code == CODE_TLB_WR);
  assign is_trap = (exc_code == CODE_TRAP);

  always_comb begin
    save_pc = pc;
    if (in_slot) save_pc = save_pc - STEP;
    if ((kind == EV_EXC) && is_trap) save_pc = save_pc + STEP;

    tgt_sr         = sr;
    tgt_sr[BIT_BL] = 1'b1;
    tgt_sr[BIT_MD] = 1'b1;
    tgt_sr[BIT_RB] = 1'b1;
    if ((kind == EV_EXC) && is_hard) begin
      tgt_sr[BIT_FD] = 1'b0;
      tgt_sr[IMASK_LO +: LVL_W] = '1;
    end

    if (kind == EV_IRQ)  tgt_pc = vbr + XLEN'(OFS_IRQ);
    else if (is_hard)    tgt_pc = XLEN'(FIXED_PC);
    else if (is_tlb)     tgt_pc = vbr + XLEN'(OFS_TLB);
    else                 tgt_pc = vbr + XLEN'(OFS_GEN);
  end

endmodule

// File: rtl/evt_entry_seq.sv
module evt_entry_seq
  import evt_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          LVL_W    = 4,
  parameter logic [31:0] FIXED_PC = 32'hA000_0000,
  parameter logic [31:0] OFS_GEN  = 32'h0000_0100,
  parameter logic [31:0] OFS_TLB  = 32'h0000_0400,
  parameter logic [31:0] OFS_IRQ  = 32'h0000_0600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_event,
  input  logic              exc_valid,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              irq_valid,
  input  logic [LVL_W-1:0]  irq_level,
  input  logic [CODE_W-1:0] irq_code,
  input  logic [XLEN-1:0]   sr_in,
  input  logic [XLEN-1:0]   pc_in,
  input  logic [XLEN-1:0]   r15_in,
  input  logic [XLEN-1:0]   vbr_in,
  input  logic              dslot_in,
  input  logic              sleep_in,
  output logic              entered,
  output logic              entry_exc,
  output logic              reset_req,
  output logic              slot_clear,
  output logic              wake,
  output logic [XLEN-1:0]   ssr,
  output logic [XLEN-1:0]   spc,
  output logic [XLEN-1:0]   sgr,
  output logic [XLEN-1:0]   sr_new,
  output logic [XLEN-1:0]   pc_new,
  output logic [CODE_W-1:0] expevt,
  output logic [CODE_W-1:0] intevt
);

  ev_kind_e        kind;
  logic [XLEN-1:0] tgt_pc;
  logic [XLEN-1:0] tgt_sr;
  logic [XLEN-1:0] save_pc;
  logic            load_any;
  logic            load_exc;
  logic            load_irq;
  logic            rst_d;

  evt_arbiter #(.LVL_W(LVL_W)) u_arb (
    .exc_valid (exc_valid),
    .exc_code  (exc_code),
    .irq_valid (irq_valid),
    .irq_level (irq_level),
    .imask     (sr_in[IMASK_LO +: LVL_W]),
    .blocked   (sr_in[BIT_BL]),
    .sleeping  (sleep_in),
    .in_slot   (dslot_in),
    .kind      (kind)
  );

  evt_target #(
    .XLEN(XLEN), .LVL_W(LVL_W), .FIXED_PC(FIXED_PC),
    .OFS_GEN(OFS_GEN), .OFS_TLB(OFS_TLB), .OFS_IRQ(OFS_IRQ)
  ) u_tgt (
    .kind     (kind),
    .exc_code (exc_code),
    .sr       (sr_in),
    .pc       (pc_in),
    .vbr      (vbr_in),
    .in_slot  (dslot_in),
    .tgt_pc   (tgt_pc),
    .tgt_sr   (tgt_sr),
    .save_pc  (save_pc)
  );

  always_comb begin
    load_exc = take_event && (kind == EV_EXC);
    load_irq = take_event && (kind == EV_IRQ);
    load_any = load_exc || load_irq;
    rst_d    = take_event && (kind == EV_RST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entered    <= 1'b0;
      entry_exc  <= 1'b0;
      reset_req  <= 1'b0;
      slot_clear <= 1'b0;
      wake       <= 1'b0;
    end else begin
      entered    <= load_any;
      reset_req  <= rst_d;
      slot_clear <= load_any && dslot_in;
      wake       <= load_any && sleep_in;
      if (load_any) entry_exc <= load_exc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ssr    <= '0;
      spc    <= '0;
      sgr    <= '0;
      sr_new <= '0;
      pc_new <= '0;
    end else if (load_any) begin
      ssr    <= sr_in;
      spc    <= save_pc;
      sgr    <= r15_in;
      sr_new <= tgt_sr;
      pc_new <= tgt_pc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      expevt <= '0;
      intevt <= '0;
    end else begin
      if (load_exc) expevt <= exc_code;
      if (load_irq) intevt <= irq_code;
    end
  end

endmodule

// File: rtl/evt_entry_seq_chk.sv
module evt_entry_seq_chk
  import evt_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          LVL_W    = 4,
  parameter logic [31:0] FIXED_PC = 32'hA000_0000,
  parameter logic [31:0] OFS_GEN  = 32'h0000_0100,
  parameter logic [31:0] OFS_TLB  = 32'h0000_0400,
  parameter logic [31:0] OFS_IRQ  = 32'h0000_0600
) (
  input logic              clk,
  input logic              rst_n,
  input logic              take_event,
  input logic              exc_valid,
  input logic [CODE_W-1:0] exc_code,
  input logic              irq_valid,
  input logic [LVL_W-1:0]  irq_level,
  input logic [CODE_W-1:0] irq_code,
  input logic [XLEN-1:0]   sr_in,
  input logic [XLEN-1:0]   pc_in,
  input logic [XLEN-1:0]   r15_in,
  input logic [XLEN-1:0]   vbr_in,
  input logic              dslot_in,
  input logic              sleep_in,
  input logic              entered,
  input logic              entry_exc,
  input logic              reset_req,
  input logic              slot_clear,
  input logic              wake,
  input logic [XLEN-1:0]   ssr,
  input logic [XLEN-1:0]   spc,
  input logic [XLEN-1:0]   sgr,
  input logic [XLEN-1:0]   sr_new,
  input logic [XLEN-1:0]   pc_new,
  input logic [CODE_W-1:0] expevt,
  input logic [CODE_W-1:0] intevt
);

  AST_EXC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (entered && $past(exc_valid)) |-> entry_exc); // R1

  AST_RESET_NO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> (!entered && $past(sr_in[BIT_BL]) && $past(exc_valid))); // R2

  AST_BLOCKED_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (entered && !entry_exc && $past(sr_in[BIT_BL])) |-> $past(sleep_in)); // R3

  AST_ABOVE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (entered && !entry_exc) |-> ($past(irq_level) > $past(sr_in[IMASK_LO +: LVL_W]))); // R4

  AST_MODE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    entered |-> (sr_new[BIT_BL] && sr_new[BIT_MD] && sr_new[BIT_RB] && (ssr == $past(sr_in)))); // R5

  AST_NO_SLOT_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (entered && !entry_exc) |-> !$past(dslot_in)); // R6

  AST_IRQ_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (entered && !entry_exc) |-> (pc_new == $past(vbr_in) + XLEN'(OFS_IRQ))); // R10

  AST_STROBE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(take_event) |-> (!entered && !reset_req && $stable(pc_new) && $stable(expevt) && $stable(intevt))); // R11

endmodule

bind evt_entry_seq evt_entry_seq_chk #(
  .XLEN(XLEN), .LVL_W(LVL_W), .FIXED_PC(FIXED_PC),
  .OFS_GEN(OFS_GEN), .OFS_TLB(OFS_TLB), .OFS_IRQ(OFS_IRQ)
) u_chk (.*);

// File: tb/evt_entry_seq_test.sv
module evt_entry_seq_test;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        take_event;
  logic        exc_valid;
  logic [11:0] exc_code;
  logic        irq_valid;
  logic [3:0]  irq_level;
  logic [11:0] irq_code;
  logic [31:0] sr_in, pc_in, r15_in, vbr_in;
  logic        dslot_in, sleep_in;
  logic        entered, entry_exc, reset_req, slot_clear, wake;
  logic [31:0] ssr, spc, sgr, sr_new, pc_new;
  logic [11:0] expevt, intevt;

  int n_chk  = 0;
  int n_fail = 0;

  logic [31:0] e_ssr, e_spc, e_sgr, e_sr, e_pc;
  logic [11:0] e_exp, e_int;
  logic        e_excf;

  evt_entry_seq uut (
    .clk(clk), .rst_n(rst_n), .take_event(take_event),
    .exc_valid(exc_valid), .exc_code(exc_code),
    .irq_valid(irq_valid), .irq_level(irq_level), .irq_code(irq_code),
    .sr_in(sr_in), .pc_in(pc_in), .r15_in(r15_in), .vbr_in(vbr_in),
    .dslot_in(dslot_in), .sleep_in(sleep_in),
    .entered(entered), .entry_exc(entry_exc), .reset_req(reset_req),
    .slot_clear(slot_clear), .wake(wake),
    .ssr(ssr), .spc(spc), .sgr(sgr), .sr_new(sr_new), .pc_new(pc_new),
    .expevt(expevt), .intevt(intevt)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_regs(input string req);
    chk(ssr == e_ssr,       req, "ssr",    ssr,    e_ssr);
    chk(spc == e_spc,       req, "spc",    spc,    e_spc);
    chk(sgr == e_sgr,       req, "sgr",    sgr,    e_sgr);
    chk(sr_new == e_sr,     req, "sr_new", sr_new, e_sr);
    chk(pc_new == e_pc,     req, "pc_new", pc_new, e_pc);
    chk(expevt == e_exp,    req, "expevt", 32'(expevt), 32'(e_exp));
    chk(intevt == e_int,    req, "intevt", 32'(intevt), 32'(e_int));
    chk(entry_exc == e_excf, req, "entry_exc", 32'(entry_exc), 32'(e_excf));
  endtask

  // Reference model built from the requirement list.
  task automatic run_event(input string tag,
                           input logic xv, input logic [11:0] xc,
                           input logic iv, input logic [3:0] il, input logic [11:0] ic,
                           input logic [31:0] sr, input logic [31:0] pc,
                           input logic [31:0] r15, input logic [31:0] vbr,
                           input logic ds, input logic sl);
    logic acc_exc, acc_irq, rst_exp, hard;
    logic [31:0] s;
    string pc_tag, spc_tag;
    acc_exc = 1'b0; acc_irq = 1'b0; rst_exp = 1'b0;
    hard = (xc == 12'h000) || (xc == 12'h020) || (xc == 12'h140);
    pc_tag = "R5"; spc_tag = "R5";
    if (xv) begin
      if (sr[28] && xc != 12'h1E0) rst_exp = 1'b1;
      else                         acc_exc = 1'b1;
    end else if (iv && !ds && (!sr[28] || sl) && (il > sr[7:4])) begin
      acc_irq = 1'b1;
    end
    if (acc_exc || acc_irq) begin
      e_ssr = sr; e_sgr = r15; e_excf = acc_exc;
      e_spc = pc - (ds ? 32'd2 : 32'd0);
      if (ds) spc_tag = "R6";
      if (acc_exc && xc == 12'h160) begin e_spc = e_spc + 32'd2; spc_tag = "R9"; end
      s = sr | 32'h7000_0000;
      if (acc_exc && hard) begin s[15] = 1'b0; s[7:4] = 4'hF; end
      e_sr = s;
      if (acc_irq) begin e_pc = vbr + 32'h600; e_int = ic; pc_tag = "R10"; end
      else begin
        e_exp = xc;
        if (hard) begin e_pc = 32'hA000_0000; pc_tag = "R7"; end
        else if (xc == 12'h040 || xc == 12'h060) begin e_pc = vbr + 32'h400; pc_tag = "R8"; end
        else begin e_pc = vbr + 32'h100; pc_tag = "R8"; end
      end
    end
    exc_valid = xv; exc_code = xc; irq_valid = iv; irq_level = il; irq_code = ic;
    sr_in = sr; pc_in = pc; r15_in = r15; vbr_in = vbr; dslot_in = ds; sleep_in = sl;
    take_event = 1'b1;
    @(negedge clk);
    take_event = 1'b0;
    chk(entered == (acc_exc || acc_irq), tag, "entered", 32'(entered), 32'(acc_exc || acc_irq));
    chk(reset_req == rst_exp, tag, "reset_req", 32'(reset_req), 32'(rst_exp));
    chk(slot_clear == ((acc_exc || acc_irq) && ds), "R6", "slot_clear", 32'(slot_clear), 32'((acc_exc || acc_irq) && ds));
    chk(wake == ((acc_exc || acc_irq) && sl), "R3", "wake", 32'(wake), 32'((acc_exc || acc_irq) && sl));
    chk(pc_new == e_pc, pc_tag, "pc_new", pc_new, e_pc);
    chk(spc == e_spc, spc_tag, "spc", spc, e_spc);
    chk_regs(tag);
    // Idle edge with a live exception offered but no strobe: nothing may move.
    exc_valid = 1'b1; exc_code = 12'h0E0; irq_valid = 1'b1; irq_level = 4'hF;
    @(negedge clk);
    chk(!entered && !reset_req, "R11", "pulse after idle edge", 32'({entered, reset_req}), 32'd0);
    chk_regs("R11");
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_fail++;
    $display("FAIL R11 watchdog: actual %h expected %h", 32'd1, 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; take_event = 1'b0; exc_valid = 1'b0; exc_code = '0;
    irq_valid = 1'b0; irq_level = '0; irq_code = '0; sr_in = '0; pc_in = '0;
    r15_in = '0; vbr_in = '0; dslot_in = 1'b0; sleep_in = 1'b0;
    e_ssr = '0; e_spc = '0; e_sgr = '0; e_sr = '0; e_pc = '0; e_exp = '0; e_int = '0; e_excf = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!entered && !reset_req && !slot_clear && !wake, "R11", "reset pulses",
        32'({entered, reset_req, slot_clear, wake}), 32'd0);
    chk_regs("R11");

    // Exception codes across block and delay-slot settings.
    for (int k = 0; k < 18; k++) begin
      for (int b = 0; b < 2; b++) begin
        for (int d = 0; d < 2; d++) begin
          logic [11:0] code;
          code = (k < 16) ? 12'(k * 32) : 12'(12'h800 + (k - 16) * 32);
          run_event(b ? "R2" : "R8", 1'b1, code, 1'b0, 4'h0, 12'h000,
                    32'h0000_80A1 | (32'(b) << 28), 32'h0C00_2000 + 32'(k * 16),
                    32'h8C7F_0000 + 32'(k), 32'h8C00_0000 + 32'(k * 4096),
                    d[0], 1'b0);
        end
      end
    end

    // Exception and interrupt pending together.
    for (int k = 0; k < 16; k++) begin
      run_event("R1", 1'b1, 12'(k * 32), 1'b1, 4'hF, 12'h3A0,
                32'h0000_0000, 32'h0C00_4000, 32'h8C7E_0000,
                32'h8800_0000 + 32'(k * 256), 1'b0, 1'b0);
    end

    // Every interrupt level against every mask, with block, sleep and slot.
    for (int lv = 0; lv < 16; lv++) begin
      for (int m = 0; m < 16; m++) begin
        for (int c = 0; c < 8; c++) begin
          logic bl, sl, ds;
          bl = c[0]; sl = c[1]; ds = c[2];
          run_event(ds ? "R6" : (bl ? "R3" : "R4"), 1'b0, 12'h000, 1'b1,
                    4'(lv), 12'h200 + 12'(lv * 32),
                    (32'(bl) << 28) | (32'(m) << 4) | 32'h0000_8003,
                    32'h0C01_0000 + 32'(lv * 64 + m * 4),
                    32'h8C7D_0000 + 32'(m), 32'h8D00_0000 + 32'(c * 65536),
                    ds, sl);
        end
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule